// File: doc/BRIEF.md
# GF(3^m) Digit-Array Multiplier

This block multiplies two elements of the extension field GF(3^m) held in polynomial basis and returns the product reduced by a monic field polynomial of degree m. Every base-3 digit is carried as a 2-bit code, so an element of m digits occupies 2m bits. Only the m lower coefficients of the field polynomial are supplied. The leading coefficient is 1 and is not sent, so the same datapath serves any polynomial of degree m.

The datapath is a regular array of digit cells, and each cell forms (a·b + c) mod 3. An m×m grid of cells builds the unreduced product of 2m−1 digits. After it come m−1 fold rows. Each fold row takes the current top digit, negates it in a small negation cell, scales every polynomial coefficient by that value and adds the results into the digits below. A parameter chooses how each cell is built: either one six-input lookup, or a mod-3 multiplier that feeds a mod-3 adder. Both builds give the same results.

The operands and the polynomial are captured on a rising clock edge. The array between those registers and the output is purely combinational, so the product appears one cycle after the inputs are presented.

Top module: `gf3m_mul`

## Requirements
- R1: A digit is coded as 2'b00 for 0, 2'b01 for 1 and 2'b10 for 2. Digit i of an element sits at bits [2i+1:2i]. The code 2'b11 never appears on r_o.
- R2: r_o equals the polynomial product of a_i and b_i with coefficients taken mod 3, reduced modulo x^m + sum of p_j·x^j, where p_j is digit j of p_i.
- R3: The lookup build (STYLE = CELL_LUT) and the multiplier-plus-adder build (STYLE = CELL_MULADD) give identical r_o for every valid input.
- R4: r_o shows the result for the a_i, b_i and p_i captured at the most recent rising edge of clk_i. A change on the inputs between edges does not alter r_o.
- R5: While rst_ni is low, the captured operands are cleared and r_o is all zeros.
- R6: When either operand is the unit element (digit 0 = 1, all other digits 0), r_o equals the other operand.
- R7: When either operand is zero, r_o is zero.
- R8: The reduction follows whatever polynomial is on p_i. The product is correct for more than one field polynomial without any change to the design.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; operands are captured on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 2*M | First operand, M digits of 2 bits each |
| b_i | input | 2*M | Second operand, M digits of 2 bits each |
| p_i | input | 2*M | Lower M coefficients of the monic field polynomial |
| r_o | output | 2*M | Reduced product |

## Verification
The bench builds two copies of the multiplier with M = 4, one for each cell build. With M = 4 there are only 81 elements, so every one of the 6561 operand pairs can be applied under x^4 + x + 2, and the full sweep is repeated under a second polynomial. Because the space is this small, every carry pattern in the grid and every fold value in the reduction rows is exercised. The two builds can also be compared pair by pair against a base-3 schoolbook model with long division.

// File: rtl/gf3_pkg.sv
package gf3_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_ZERO = 2'b00;
  localparam trit_t TRIT_ONE  = 2'b01;
  localparam trit_t TRIT_TWO  = 2'b10;

  typedef enum logic {
    CELL_LUT    = 1'b0,
    CELL_MULADD = 1'b1
  } cell_style_e;

  // single lookup over all six input bits
  function automatic trit_t mac_lut(trit_t a, trit_t b, trit_t c);
    int unsigned v;
    v = (int'(a) * int'(b) + int'(c)) % 3;
    return v[1:0];
  endfunction

  // mod-3 product of two digits
  function automatic trit_t mul3(trit_t a, trit_t b);
    if (a == TRIT_ZERO || b == TRIT_ZERO) return TRIT_ZERO;
    return (a == b) ? TRIT_ONE : TRIT_TWO;
  endfunction

  // mod-3 sum of two digits
  function automatic trit_t add3(trit_t a, trit_t c);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, c};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction
endpackage

// File: rtl/gf3_cell.sv
module gf3_cell #(
  parameter gf3_pkg::cell_style_e STYLE = gf3_pkg::CELL_LUT
) (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  input  logic [1:0] c_i,
  output logic [1:0] s_o
);
  generate
    if (STYLE == gf3_pkg::CELL_LUT) begin : g_lut
      assign s_o = gf3_pkg::mac_lut(a_i, b_i, c_i);
    end else begin : g_muladd
      logic [1:0] prod;
      assign prod = gf3_pkg::mul3(a_i, b_i);
      assign s_o  = gf3_pkg::add3(prod, c_i);
    end
  endgenerate
endmodule

// File: rtl/gf3_neg.sv
module gf3_neg (
  input  logic [1:0] a_i,
  output logic [1:0] n_o
);
  // -1 = 2 and -2 = 1 mod 3: swap the code bits
  assign n_o = {a_i[0], a_i[1]};
endmodule

// File: rtl/gf3_mul_core.sv
module gf3_mul_core #(
  parameter int M = 4,
  parameter gf3_pkg::cell_style_e STYLE = gf3_pkg::CELL_LUT,
  localparam int W  = 2 * M,
  localparam int ND = 2 * M - 1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] p_i,
  output logic [W-1:0] r_o
);
  logic [1:0] pp [0:M][0:ND-1];
  logic [1:0] rd [0:M-1][0:ND-1];
  logic [1:0] fold [0:M-1];

  generate
    for (genvar d = 0; d < ND; d++) begin : g_init
      assign pp[0][d] = 2'b00;
    end

    // partial-product grid: row r adds a[r]*b into digits r..r+M-1
    for (genvar r = 0; r < M; r++) begin : g_row
      for (genvar d = 0; d < ND; d++) begin : g_dig
        if (d >= r && d < r + M) begin : g_cell
          gf3_cell #(.STYLE(STYLE)) u_cell (
            .a_i(a_i[2*r +: 2]),
            .b_i(b_i[2*(d-r) +: 2]),
            .c_i(pp[r][d]),
            .s_o(pp[r+1][d])
          );
        end else begin : g_pass
          assign pp[r+1][d] = pp[r][d];
        end
      end
    end

    for (genvar d = 0; d < ND; d++) begin : g_hand
      assign rd[0][d] = pp[M][d];
    end

    // fold rows: top digit t at degree k adds (-t)*p_j into degree k-M+j
    for (genvar s = 0; s < M - 1; s++) begin : g_fold
      localparam int K = ND - 1 - s;
      gf3_neg u_neg (.a_i(rd[s][K]), .n_o(fold[s]));
      for (genvar d = 0; d < ND; d++) begin : g_dig
        if (d >= K - M && d < K) begin : g_cell
          gf3_cell #(.STYLE(STYLE)) u_cell (
            .a_i(fold[s]),
            .b_i(p_i[2*(d-K+M) +: 2]),
            .c_i(rd[s][d]),
            .s_o(rd[s+1][d])
          );
        end else if (d == K) begin : g_drop
          assign rd[s+1][d] = 2'b00;
        end else begin : g_pass
          assign rd[s+1][d] = rd[s][d];
        end
      end
    end
    assign fold[M-1] = 2'b00;

    for (genvar d = 0; d < M; d++) begin : g_out
      assign r_o[2*d +: 2] = rd[M-1][d];
    end
  endgenerate
endmodule

// File: rtl/gf3m_mul.sv
module gf3m_mul #(
  parameter int M = 4,
  parameter gf3_pkg::cell_style_e STYLE = gf3_pkg::CELL_LUT,
  localparam int W = 2 * M
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] p_i,
  output logic [W-1:0] r_o
);
  logic [W-1:0] a_q, b_q, p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
      p_q <= '0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
      p_q <= p_i;
    end
  end

  gf3_mul_core #(.M(M), .STYLE(STYLE)) u_core (
    .a_i(a_q),
    .b_i(b_q),
    .p_i(p_q),
    .r_o(r_o)
  );
endmodule

// File: rtl/gf3m_mul_chk.sv
module gf3m_mul_chk #(
  parameter int M = 4,
  parameter gf3_pkg::cell_style_e STYLE = gf3_pkg::CELL_LUT,
  localparam int W = 2 * M
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] p_i,
  input logic [W-1:0] r_o
);
  localparam gf3_pkg::cell_style_e ALT =
    (STYLE == gf3_pkg::CELL_LUT) ? gf3_pkg::CELL_MULADD : gf3_pkg::CELL_LUT;
  localparam logic [W-1:0] UNIT = W'(1);

  logic [W-1:0] alt_r;

  // same operands through the other cell build
  gf3_mul_core #(.M(M), .STYLE(ALT)) u_alt (
    .a_i(a_i), .b_i(b_i), .p_i(p_i), .r_o(alt_r)
  );

  for (genvar g = 0; g < M; g++) begin : g_code
    p_digit_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      r_o[2*g +: 2] != 2'b11);
  end

  p_style_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> r_o == $past(alt_r));

  p_unit_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_i == UNIT |=> r_o == $past(b_i));

  p_unit_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_i == UNIT |=> r_o == $past(a_i));

  p_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0 || b_i == '0) |=> r_o == '0);
endmodule

bind gf3m_mul gf3m_mul_chk #(.M(M), .STYLE(STYLE)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .p_i(p_i), .r_o(r_o)
);

// File: tb/test_gf3m_mul.sv
`timescale 1ns/1ps
module test_gf3m_mul;
  localparam int M = 4;
  localparam int W = 2 * M;
  localparam int NE = 81;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_s = '0, b_s = '0, p_s = '0;
  logic [W-1:0] r_lut, r_ma;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gf3m_mul #(.M(M), .STYLE(gf3_pkg::CELL_LUT)) i_gf3m_mul (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_s), .b_i(b_s), .p_i(p_s), .r_o(r_lut)
  );
  gf3m_mul #(.M(M), .STYLE(gf3_pkg::CELL_MULADD)) i_gf3m_mul_ma (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_s), .b_i(b_s), .p_i(p_s), .r_o(r_ma)
  );

  function automatic logic [W-1:0] to_elem(int n);
    logic [W-1:0] v;
    int x;
    x = n;
    for (int i = 0; i < M; i++) begin
      v[2*i +: 2] = 2'(x % 3);
      x = x / 3;
    end
    return v;
  endfunction

  // schoolbook product then long division by the monic polynomial
  function automatic logic [W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] p);
    int pr [2*M-1];
    int t;
    logic [W-1:0] v;
    for (int k = 0; k < 2*M-1; k++) pr[k] = 0;
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        pr[i+j] += int'(a[2*i +: 2]) * int'(b[2*j +: 2]);
    for (int k = 2*M-2; k >= M; k--) begin
      t = pr[k] % 3;
      pr[k] = 0;
      for (int j = 0; j < M; j++)
        pr[k-M+j] += ((3 - t) % 3) * int'(p[2*j +: 2]);
    end
    for (int i = 0; i < M; i++) v[2*i +: 2] = 2'(pr[i] % 3);
    return v;
  endfunction

  function automatic bit has_bad_code(logic [W-1:0] v);
    for (int i = 0; i < M; i++) if (v[2*i +: 2] == 2'b11) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive after a falling edge, sample at the following falling edge
  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] p);
    @(negedge clk);
    a_s = a; b_s = b; p_s = p;
    @(negedge clk);
  endtask

  task automatic sweep(logic [W-1:0] p, string req);
    logic [W-1:0] a, b, e;
    for (int i = 0; i < NE; i++) begin
      for (int j = 0; j < NE; j++) begin
        a = to_elem(i);
        b = to_elem(j);
        e = ref_mul(a, b, p);
        apply(a, b, p);
        check(req, r_lut, e);
        check({req, " R3"}, r_ma, r_lut);
        if (j == i) begin
          check("R1 lut", {7'b0, has_bad_code(r_lut)}, '0);
          check("R1 muladd", {7'b0, has_bad_code(r_ma)}, '0);
        end
      end
    end
  endtask

  localparam logic [W-1:0] POLY_A = 8'b0000_0110; // x^4 + x + 2
  localparam logic [W-1:0] POLY_B = 8'b1000_0110; // x^4 + 2x^3 + x + 2
  localparam logic [W-1:0] UNIT   = 8'b0000_0001;

  initial begin
    a_s = to_elem(50); b_s = to_elem(77); p_s = POLY_A;
    repeat (3) @(negedge clk);
    check("R5 reset lut", r_lut, '0);
    check("R5 reset muladd", r_ma, '0);
    rst_n = 1'b1;

    // R4: result stays on the captured operands until the next edge
    apply(to_elem(5), to_elem(7), POLY_A);
    check("R4 captured", r_lut, ref_mul(to_elem(5), to_elem(7), POLY_A));
    a_s = to_elem(40); b_s = to_elem(62);
    #1;
    check("R4 hold between edges", r_lut, ref_mul(to_elem(5), to_elem(7), POLY_A));
    @(negedge clk);
    check("R4 next edge", r_lut, ref_mul(to_elem(40), to_elem(62), POLY_A));

    // R6 / R7 directed
    for (int i = 0; i < NE; i++) begin
      apply(UNIT, to_elem(i), POLY_A);
      check("R6 unit*b", r_lut, to_elem(i));
      apply(to_elem(i), UNIT, POLY_B);
      check("R6 a*unit", r_ma, to_elem(i));
      apply('0, to_elem(i), POLY_A);
      check("R7 zero*b", r_lut, '0);
      apply(to_elem(i), '0, POLY_B);
      check("R7 a*zero", r_ma, '0);
    end

    sweep(POLY_A, "R2");
    sweep(POLY_B, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule